// File: doc/BRIEF.md
# Banked Data Address Generator

This block forms the 12-bit data-memory address and the result destination for one instruction of an 8-bit microcontroller core. The address comes from one of three sources. A direct operand supplies an 8-bit literal, which is widened either by a 4-bit bank number or by a fixed access-bank map. A memory-to-memory move supplies a whole 12-bit address. Third, any access whose address lands on a pointer alias takes its address from one of three pointer registers instead. Depending on the alias, that pointer is then left alone, stepped up or down, or offset by the working-register value.

The pointers live in the high part of the data space. A write-back to the low or high byte of a pointer therefore reloads that byte, and a separate load mode sets a whole pointer in one step. Decode, the ALU and the RAM sit outside the block. The core feeds in the mode and operand fields, the working-register value and the byte it is about to write back. It uses `addr_o`, `to_w_o` and `wb_o` in the same cycle.

Top module: `dmem_addr_gen`

## Requirements
- R1: In direct mode (`mode_i`=0) with `use_bank_i`=1, `addr_o` is `{bank_i, lit_i}`, unless that address is a pointer alias (R5).
- R2: In direct mode with `use_bank_i`=0, `bank_i` is ignored. A literal below 0x60 maps to 0x000 plus the literal, and a literal of 0x60 or above maps to 0xF00 plus the literal.
- R3: In full-address mode (`mode_i`=1), `addr_o` is `full_addr_i` and `bank_i`/`use_bank_i` are ignored. The result always goes to memory: `wb_o`=1 and `to_w_o`=0.
- R4: In direct mode, `dest_i`=1 gives `wb_o`=1 and `to_w_o`=0, and `dest_i`=0 gives `to_w_o`=1 and `wb_o`=0. The two flags are never high together.
- R5: Pointer k (k=0..2) owns the 8-byte block starting at 0xFD8+8k. Offset 0 is its low byte and offset 1 is its high byte. Offset 2 is the plain alias, offset 3 the post-increment alias, offset 4 the post-decrement alias and offset 5 the pre-offset alias. A direct or full-address access to any of the four aliases outputs an address taken from pointer k.
- R6: Post-increment and post-decrement accesses output the pointer's current value. The pointer then changes by one, modulo 4096, and the new value is visible from the next cycle.
- R7: A pre-offset access outputs the pointer plus `wreg_i` read as a signed byte, modulo 4096, and leaves the pointer unchanged.
- R8: Load mode (`mode_i`=2) copies `full_addr_i` into the pointer chosen by `ptr_sel_i`, with effect on the next cycle. During a load, `addr_o` is 0 and both flags are 0.
- R9: A cycle with `wb_o`=1 and `addr_o` equal to a pointer's low-byte address loads `wb_data_i` into the low byte. At the high-byte address it loads `wb_data_i[3:0]` into bits 11:8. This byte write takes priority over that pointer's own step in the same cycle: the other byte keeps its value from before the access.
- R10: Idle mode (`mode_i`=3) gives `addr_o`=0 and both flags 0, and leaves every pointer unchanged.
- R11: Reset clears all three pointers to 0x000.
- R12: A loop that loads pointer 0 with 0x100, writes zero through the post-increment alias, and stops once bit 9 of the pointer is set runs exactly 256 times. It clears 0x100–0x1FF and touches neither 0x0FF nor 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 direct, 1 full address, 2 load pointer, 3 idle |
| lit_i | input | 8 | Address literal of a direct operand |
| use_bank_i | input | 1 | 1 selects banked widening, 0 the access-bank map |
| bank_i | input | 4 | Current bank number |
| full_addr_i | input | 12 | Whole address (full mode) or pointer value (load mode) |
| dest_i | input | 1 | Direct-mode destination: 1 memory, 0 working register |
| ptr_sel_i | input | 2 | Pointer chosen by load mode |
| wreg_i | input | 8 | Working-register value used as signed offset |
| wb_data_i | input | 8 | Byte written back this cycle |
| addr_o | output | 12 | Effective data address |
| to_w_o | output | 1 | Result goes to the working register |
| wb_o | output | 1 | Result is written to memory at `addr_o` |

## Verification
The bench probes the access-bank boundary at literals 0x5F and 0x60. A wrong split compare would send one of them to the opposite end of the data space. It steps pointers across 0xFFF/0x000 in both directions and applies a negative pre-offset that crosses zero; a design that drops the carry or treats the offset as unsigned outputs an address off by 4096 or by 256. It also writes back through a post-increment alias while the pointer points at its own low byte. A design with the wrong write priority would keep the incremented value instead of the written byte. Finally, the bench runs the bank-clearing loop, where an off-by-one in the post-increment timing shows up as a wrong iteration count or a clobbered neighbour byte.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned AW = 12;            // data address width
  localparam int unsigned LW = 8;             // literal / byte width
  localparam int unsigned HW = AW - LW;       // bank / high-byte width
  localparam int unsigned BLK_SPAN = 8;       // addresses owned by one pointer

  typedef logic [AW-1:0] addr_t;
  typedef logic [LW-1:0] byte_t;

  typedef enum logic [1:0] {
    MD_DIRECT = 2'd0,
    MD_FULL   = 2'd1,
    MD_LOAD   = 2'd2,
    MD_IDLE   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    AK_NONE, AK_LO, AK_HI, AK_PLAIN, AK_INC, AK_DEC, AK_OFS
  } alias_e;

  // widen a literal through the access-bank map
  function automatic addr_t access_map(byte_t lit, byte_t split);
    if (lit < split) return {{HW{1'b0}}, lit};
    return {{HW{1'b1}}, lit};
  endfunction

  // sign-extend a byte to a full address-width delta
  function automatic addr_t sext_byte(byte_t b);
    return {{HW{b[LW-1]}}, b};
  endfunction

  // modulo-2^AW add
  function automatic addr_t wrap_add(addr_t p, addr_t d);
    return p + d;
  endfunction

  // classify an address against one pointer's block
  function automatic alias_e alias_kind(addr_t a, addr_t blk);
    addr_t off;
    off = a - blk;
    if (off >= addr_t'(BLK_SPAN)) return AK_NONE;
    case (off[2:0])
      3'd0:    return AK_LO;
      3'd1:    return AK_HI;
      3'd2:    return AK_PLAIN;
      3'd3:    return AK_INC;
      3'd4:    return AK_DEC;
      3'd5:    return AK_OFS;
      default: return AK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dag_raw_addr.sv
module dag_raw_addr
  import dag_pkg::*;
#(
  parameter byte_t SPLIT = 8'h60
) (
  input  mode_e        mode,
  input  byte_t        lit,
  input  logic         use_bank,
  input  logic [HW-1:0] bank,
  input  addr_t        full_addr,
  output addr_t        raw_addr,
  output logic         acc_en
);
  always_comb begin
    if (mode == MD_FULL)   raw_addr = full_addr;
    else if (use_bank)     raw_addr = {bank, lit};
    else                   raw_addr = access_map(lit, SPLIT);
  end

  assign acc_en = (mode == MD_DIRECT) || (mode == MD_FULL);
endmodule

// File: rtl/dag_ptr_slice.sv
module dag_ptr_slice
  import dag_pkg::*;
#(
  parameter addr_t BLK = 12'hFD8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc_en,
  input  addr_t raw_addr,
  input  logic  load_en,
  input  addr_t load_val,
  input  byte_t w_val,
  input  logic  wb_en,
  input  addr_t fin_addr,
  input  byte_t wb_data,
  output logic  hit_o,
  output addr_t addr_o,
  output addr_t ptr_o,
  output logic  inc_o,
  output logic  dec_o,
  output logic  ofs_o,
  output logic  sfr_o
);
  addr_t  ptr_q, ptr_d;
  alias_e kind;
  logic   lo_wr, hi_wr;

  assign kind  = acc_en ? alias_kind(raw_addr, BLK) : AK_NONE;
  assign hit_o = (kind == AK_PLAIN) || (kind == AK_INC) ||
                 (kind == AK_DEC)   || (kind == AK_OFS);
  assign inc_o = (kind == AK_INC);
  assign dec_o = (kind == AK_DEC);
  assign ofs_o = (kind == AK_OFS);

  assign addr_o = ofs_o ? wrap_add(ptr_q, sext_byte(w_val)) : ptr_q;

  assign lo_wr = wb_en && (fin_addr == BLK);
  assign hi_wr = wb_en && (fin_addr == BLK + addr_t'(1));
  assign sfr_o = lo_wr || hi_wr;

  always_comb begin
    ptr_d = ptr_q;
    if (sfr_o) begin
      if (lo_wr) ptr_d[LW-1:0]  = wb_data;
      if (hi_wr) ptr_d[AW-1:LW] = wb_data[HW-1:0];
    end else if (inc_o) begin
      ptr_d = wrap_add(ptr_q, addr_t'(1));
    end else if (dec_o) begin
      ptr_d = wrap_add(ptr_q, '1);
    end
    if (load_en) ptr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dag_ptr_bank.sv
module dag_ptr_bank
  import dag_pkg::*;
#(
  parameter int unsigned NPTR     = 3,
  parameter addr_t       PTR_BASE = 12'hFD8,
  localparam int unsigned SELW    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  addr_t                    raw_addr,
  input  logic                     load_req,
  input  logic [SELW-1:0]          load_sel,
  input  addr_t                    load_val,
  input  byte_t                    w_val,
  input  logic                     wb_en,
  input  addr_t                    fin_addr,
  input  byte_t                    wb_data,
  output logic [NPTR-1:0]          hit,
  output logic [NPTR-1:0][AW-1:0]  ind_addr,
  output logic [NPTR-1:0][AW-1:0]  ptr_q,
  output logic [NPTR-1:0]          ev_inc,
  output logic [NPTR-1:0]          ev_dec,
  output logic [NPTR-1:0]          ev_ofs,
  output logic [NPTR-1:0]          ev_sfr
);
  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    localparam addr_t BLK = PTR_BASE + addr_t'(k * BLK_SPAN);
    dag_ptr_slice #(.BLK(BLK)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (acc_en),
      .raw_addr (raw_addr),
      .load_en  (load_req && (load_sel == SELW'(k))),
      .load_val (load_val),
      .w_val    (w_val),
      .wb_en    (wb_en),
      .fin_addr (fin_addr),
      .wb_data  (wb_data),
      .hit_o    (hit[k]),
      .addr_o   (ind_addr[k]),
      .ptr_o    (ptr_q[k]),
      .inc_o    (ev_inc[k]),
      .dec_o    (ev_dec[k]),
      .ofs_o    (ev_ofs[k]),
      .sfr_o    (ev_sfr[k])
    );
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dag_pkg::*;
#(
  parameter int unsigned NPTR     = 3,
  parameter addr_t       PTR_BASE = 12'hFD8,
  parameter byte_t       SPLIT    = 8'h60,
  localparam int unsigned SELW    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic [LW-1:0]   lit_i,
  input  logic            use_bank_i,
  input  logic [HW-1:0]   bank_i,
  input  logic [AW-1:0]   full_addr_i,
  input  logic            dest_i,
  input  logic [SELW-1:0] ptr_sel_i,
  input  logic [LW-1:0]   wreg_i,
  input  logic [LW-1:0]   wb_data_i,
  output logic [AW-1:0]   addr_o,
  output logic            to_w_o,
  output logic            wb_o
);
  mode_e                   mode;
  addr_t                   raw_addr, addr_sel;
  logic                    acc_en;
  logic [NPTR-1:0]         hit;
  logic [NPTR-1:0][AW-1:0] ind_addr;
  // named internal events for the checker
  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [NPTR-1:0]         ev_inc, ev_dec, ev_ofs, ev_sfr;
  logic                    ind_hit;

  assign mode = mode_e'(mode_i);

  dag_raw_addr #(.SPLIT(SPLIT)) u_raw (
    .mode      (mode),
    .lit       (lit_i),
    .use_bank  (use_bank_i),
    .bank      (bank_i),
    .full_addr (full_addr_i),
    .raw_addr  (raw_addr),
    .acc_en    (acc_en)
  );

  dag_ptr_bank #(.NPTR(NPTR), .PTR_BASE(PTR_BASE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .raw_addr (raw_addr),
    .load_req (mode == MD_LOAD),
    .load_sel (ptr_sel_i),
    .load_val (full_addr_i),
    .w_val    (wreg_i),
    .wb_en    (wb_o),
    .fin_addr (addr_o),
    .wb_data  (wb_data_i),
    .hit      (hit),
    .ind_addr (ind_addr),
    .ptr_q    (ptr_q),
    .ev_inc   (ev_inc),
    .ev_dec   (ev_dec),
    .ev_ofs   (ev_ofs),
    .ev_sfr   (ev_sfr)
  );

  assign ind_hit = |hit;

  always_comb begin
    addr_sel = raw_addr;
    for (int k = 0; k < NPTR; k++) begin
      if (hit[k]) addr_sel = ind_addr[k];
    end
  end

  assign addr_o = acc_en ? addr_sel : '0;
  assign to_w_o = (mode == MD_DIRECT) && !dest_i;
  assign wb_o   = ((mode == MD_DIRECT) && dest_i) || (mode == MD_FULL);
endmodule

// File: rtl/dmem_addr_gen_chk.sv
module dmem_addr_gen_chk
  import dag_pkg::*;
#(
  parameter int unsigned NPTR = 3,
  localparam int unsigned SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode_i,
  input logic                    use_bank_i,
  input logic [LW-1:0]           lit_i,
  input logic [AW-1:0]           full_addr_i,
  input logic [SELW-1:0]         ptr_sel_i,
  input logic [AW-1:0]           addr_o,
  input logic                    to_w_o,
  input logic                    wb_o,
  input logic                    ind_hit,
  input logic [NPTR-1:0][AW-1:0] ptr_q,
  input logic [NPTR-1:0]         ev_inc,
  input logic [NPTR-1:0]         ev_dec,
  input logic [NPTR-1:0]         ev_ofs,
  input logic [NPTR-1:0]         ev_sfr
);
  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_w_o && wb_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |-> (addr_o == '0 && !to_w_o && !wb_o));

  // R3
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && !ind_hit) |-> (addr_o == full_addr_i && wb_o && !to_w_o));

  // R2
  access_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && !use_bank_i && !ind_hit && lit_i < 8'h60)
      |-> (addr_o[AW-1:LW] == '0));

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ptr_q == '0));

  for (genvar k = 0; k < NPTR; k++) begin : g_chk
    // R6
    post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_inc[k] && !ev_sfr[k] && !(mode_i == 2'd2))
        |=> (ptr_q[k] == addr_t'($past(ptr_q[k]) + addr_t'(1))));
    // R6
    post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_dec[k] && !ev_sfr[k] && !(mode_i == 2'd2))
        |=> (ptr_q[k] == addr_t'($past(ptr_q[k]) - addr_t'(1))));
    // R7
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_ofs[k] && !ev_sfr[k]) |=> $stable(ptr_q[k]));
    // R8
    load_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd2 && ptr_sel_i == SELW'(k)) |=> (ptr_q[k] == $past(full_addr_i)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd3) |=> $stable(ptr_q[k]));
  end
endmodule

bind dmem_addr_gen dmem_addr_gen_chk #(.NPTR(NPTR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .use_bank_i  (use_bank_i),
  .lit_i       (lit_i),
  .full_addr_i (full_addr_i),
  .ptr_sel_i   (ptr_sel_i),
  .addr_o      (addr_o),
  .to_w_o      (to_w_o),
  .wb_o        (wb_o),
  .ind_hit     (ind_hit),
  .ptr_q       (ptr_q),
  .ev_inc      (ev_inc),
  .ev_dec      (ev_dec),
  .ev_ofs      (ev_ofs),
  .ev_sfr      (ev_sfr)
);

// File: tb/dmem_addr_gen_tb.sv
module dmem_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd3;
  logic [7:0]  lit_i = '0;
  logic        use_bank_i = 1'b0;
  logic [3:0]  bank_i = '0;
  logic [11:0] full_addr_i = '0;
  logic        dest_i = 1'b0;
  logic [1:0]  ptr_sel_i = '0;
  logic [7:0]  wreg_i = '0;
  logic [7:0]  wb_data_i = '0;
  logic [11:0] addr_o;
  logic        to_w_o, wb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ram [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lit_i(lit_i),
    .use_bank_i(use_bank_i), .bank_i(bank_i), .full_addr_i(full_addr_i),
    .dest_i(dest_i), .ptr_sel_i(ptr_sel_i), .wreg_i(wreg_i),
    .wb_data_i(wb_data_i), .addr_o(addr_o), .to_w_o(to_w_o), .wb_o(wb_o)
  );

  // behavioural RAM for the low kilobyte
  always @(posedge clk) begin
    if (wb_o && addr_o < 12'd1024) ram[addr_o[9:0]] <= wb_data_i;
  end

  // pointer block layout (R5): base 0xFD8 + 8k
  function automatic logic [7:0] blk_lit(int k, int off);
    return 8'(8'hD8 + 8 * k + off);
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [7:0] l, input logic u,
                       input logic [3:0] b, input logic [11:0] f, input logic d,
                       input logic [1:0] s, input logic [7:0] wv, input logic [7:0] wd);
    @(negedge clk);
    mode_i = m; lit_i = l; use_bank_i = u; bank_i = b; full_addr_i = f;
    dest_i = d; ptr_sel_i = s; wreg_i = wv; wb_data_i = wd;
    #1;
  endtask

  task automatic go_idle();
    drive(2'd3, 8'h00, 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
  endtask

  task automatic load_ptr(int k, logic [11:0] v);
    drive(2'd2, 8'h00, 1'b0, 4'h0, v, 1'b0, 2'(k), 8'h00, 8'h00);
  endtask

  // read pointer k through its plain alias, result to W (no side effect)
  task automatic peek(int k, output logic [11:0] v);
    drive(2'd0, blk_lit(k, 2), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    v = addr_o;
  endtask

  task automatic t_reset();
    logic [11:0] v;
    for (int k = 0; k < 3; k++) begin
      peek(k, v);
      chk($sformatf("R11 pointer %0d after reset", k), v, 12'h000);
    end
  endtask

  task automatic t_banked();
    drive(2'd0, 8'h3C, 1'b1, 4'h5, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R1 bank 5 lit 3C", addr_o, 12'h53C);
    drive(2'd0, 8'hDA, 1'b1, 4'hA, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R1 bank A lit DA is not an alias", addr_o, 12'hADA);
  endtask

  task automatic t_access();
    drive(2'd0, 8'h5F, 1'b0, 4'h7, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R2 lit 5F low region", addr_o, 12'h05F);
    drive(2'd0, 8'h60, 1'b0, 4'h7, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R2 lit 60 high region", addr_o, 12'hF60);
    drive(2'd0, 8'hFF, 1'b0, 4'h3, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R2 lit FF high region", addr_o, 12'hFFF);
  endtask

  task automatic t_full();
    drive(2'd1, 8'h12, 1'b1, 4'h2, 12'h7A3, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R3 full address", addr_o, 12'h7A3);
    chk("R3 full wb", {11'd0, wb_o}, 12'd1);
    chk("R3 full to_w", {11'd0, to_w_o}, 12'd0);
  endtask

  task automatic t_dest();
    drive(2'd0, 8'h20, 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R4 dest0 flags {to_w,wb}", {10'd0, to_w_o, wb_o}, 12'd2);
    drive(2'd0, 8'h20, 1'b0, 4'h0, 12'h000, 1'b1, 2'd0, 8'h00, 8'h00);
    chk("R4 dest1 flags {to_w,wb}", {10'd0, to_w_o, wb_o}, 12'd1);
  endtask

  task automatic t_load();
    logic [11:0] v;
    load_ptr(1, 12'h345);
    chk("R8 load addr_o", addr_o, 12'h000);
    chk("R8 load flags", {10'd0, to_w_o, wb_o}, 12'd0);
    peek(1, v);
    chk("R8 pointer 1 loaded", v, 12'h345);
    peek(0, v);
    chk("R8 pointer 0 untouched", v, 12'h000);
  endtask

  task automatic t_step();
    logic [11:0] v;
    load_ptr(2, 12'hFFF);
    drive(2'd0, blk_lit(2, 3), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R6 post-inc uses old value", addr_o, 12'hFFF);
    peek(2, v);
    chk("R6 post-inc wraps to 000", v, 12'h000);
    drive(2'd0, blk_lit(2, 4), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R6 post-dec uses old value", addr_o, 12'h000);
    peek(2, v);
    chk("R6 post-dec wraps to FFF", v, 12'hFFF);
    // R5: alias reached through full-address mode
    drive(2'd1, 8'h00, 1'b0, 4'h0, 12'hFE2, 1'b0, 2'd0, 8'h00, 8'h00);
    chk("R5 full-mode plain alias of pointer 1", addr_o, 12'h345);
  endtask

  task automatic t_offset();
    logic [11:0] v;
    drive(2'd0, blk_lit(1, 5), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h10, 8'h00);
    chk("R7 offset +16", addr_o, 12'h355);
    drive(2'd0, blk_lit(1, 5), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'hF0, 8'h00);
    chk("R7 offset -16", addr_o, 12'h335);
    peek(1, v);
    chk("R7 pointer unchanged", v, 12'h345);
    load_ptr(0, 12'h005);
    drive(2'd0, blk_lit(0, 5), 1'b0, 4'h0, 12'h000, 1'b0, 2'd0, 8'h80, 8'h00);
    chk("R7 offset -128 wraps", addr_o, 12'hF85);
  endtask

  task automatic t_sfr();
    logic [11:0] v;
    drive(2'd0, blk_lit(1, 0), 1'b0, 4'h0, 12'h000, 1'b1, 2'd0, 8'h00, 8'h9C);
    chk("R9 low-byte write address", addr_o, 12'hFE0);
    peek(1, v);
    chk("R9 low byte loaded", v, 12'h39C);
    drive(2'd0, blk_lit(1, 1), 1'b0, 4'h0, 12'h000, 1'b1, 2'd0, 8'h00, 8'hA7);
    peek(1, v);
    chk("R9 high byte loaded", v, 12'h79C);
    // write through post-inc while pointer 0 points at its own low byte
    load_ptr(0, 12'hFD8);
    drive(2'd0, blk_lit(0, 3), 1'b0, 4'h0, 12'h000, 1'b1, 2'd0, 8'h00, 8'h34);
    chk("R9 collision address", addr_o, 12'hFD8);
    peek(0, v);
    chk("R9 byte write beats increment", v, 12'hF34);
  endtask

  task automatic t_idle();
    logic [11:0] v;
    drive(2'd3, blk_lit(1, 3), 1'b0, 4'h0, 12'hFE3, 1'b1, 2'd1, 8'h55, 8'h11);
    chk("R10 idle addr", addr_o, 12'h000);
    chk("R10 idle flags", {10'd0, to_w_o, wb_o}, 12'd0);
    go_idle();
    peek(1, v);
    chk("R10 pointer 1 kept over idle", v, 12'h79C);
  endtask

  task automatic t_clear_loop();
    logic [11:0] v;
    int iters;
    for (int a = 12'h0FF; a <= 12'h200; a++)
      drive(2'd1, 8'h00, 1'b0, 4'h0, 12'(a), 1'b0, 2'd0, 8'h00,
            (a == 12'h0FF || a == 12'h200) ? 8'hA5 : 8'h5A);
    load_ptr(0, 12'h100);
    iters = 0;
    v = 12'h100;
    while (!v[9] && iters < 300) begin
      drive(2'd0, blk_lit(0, 3), 1'b0, 4'h0, 12'h000, 1'b1, 2'd0, 8'h00, 8'h00);
      peek(0, v);
      iters++;
    end
    go_idle();
    chk("R12 iteration count", 12'(iters), 12'd256);
    chk("R12 final pointer", v, 12'h200);
    begin
      int bad = 0;
      for (int a = 12'h100; a <= 12'h1FF; a++) if (ram[a] !== 8'h00) bad++;
      chk("R12 nonzero bytes in cleared bank", 12'(bad), 12'd0);
    end
    chk("R12 byte below kept", {4'd0, ram[10'h0FF]}, 12'h0A5);
    chk("R12 byte above kept", {4'd0, ram[10'h200]}, 12'h0A5);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_banked();
    t_access();
    t_full();
    t_dest();
    t_load();
    t_step();
    t_offset();
    t_sfr();
    t_idle();
    t_clear_loop();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end
endmodule